// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Channel

This block is one counter channel whose function is picked by a three-bit mode input. It can run as a free-running interval divider or as an event divider. It can measure the time between a start and a later rising edge on the trigger input. It can produce a single delayed pulse, or measure how long the trigger input stays high. A single option bit changes how a start behaves. In the interval and capture modes it decides whether the start itself raises an interrupt and flips the timer output. In the one-shot mode it decides whether a new trigger that arrives while the count runs is honoured.

The channel takes a software start pulse, an external trigger/capture level, an event level, the mode code, the option bit and a compare/reload value. It returns the live count, a capture register, a one-clock interrupt pulse and a toggling timer output. Edges on the trigger and event inputs are found by comparing each input with its value one clock earlier. The inputs are assumed to be synchronous to `clk` already.

Top module: `timer_channel`

## Requirements
- R1: After reset, count_o, capt_o, irq_o and tout_o are all zero.
- R2: Mode codes are 000 interval, 010 capture, 011 event counter, 100 one-count and 110 capture-and-one-count. Any other code (001, 101, 111) stops the channel, forces the count to zero on the next edge, raises no interrupt and leaves tout_o unchanged.
- R3: A change of mode_i from one valid code to another stops the channel. The count holds its value until the next start.
- R4: In interval mode a start_i pulse loads cmp_i. The count then decrements once per clock. On the clock after it reaches zero it reloads cmp_i, pulses irq_o for one clock and toggles tout_o, which gives a period of cmp_i+1 clocks. A start while running is ignored.
- R5: In interval and capture modes with opt_i=1, the start edge itself pulses irq_o and toggles tout_o. With opt_i=0 the start does neither.
- R6: In capture mode a start clears the count, which then increments every clock. A rising trig_i edge copies the count into capt_o, pulses irq_o and clears the count. The output does not toggle on a capture.
- R7: In event counter mode a start loads cmp_i with no interrupt and no toggle, whatever opt_i is. The count decrements only on rising evt_i edges. The event that finds it at zero reloads cmp_i, pulses irq_o and toggles tout_o.
- R8: In one-count mode a start_i pulse or a rising trig_i edge loads cmp_i with no interrupt. The count decrements each clock. On the clock after it reaches zero the channel pulses irq_o, toggles tout_o and stops with the count at zero.
- R9: In one-count mode with opt_i=0, a trigger while counting is ignored.
- R10: In one-count mode with opt_i=1, a trigger while counting reloads cmp_i and raises no interrupt in that cycle.
- R11: In capture-and-one-count mode a start_i pulse or a rising trig_i edge clears the count and starts counting up, with no interrupt and no toggle. Triggers while counting are ignored. A falling trig_i edge copies the count into capt_o, pulses irq_o and stops the channel.
- R12: tout_o and capt_o change only in a cycle in which irq_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Software start pulse |
| trig_i | input | 1 | External trigger / capture level |
| evt_i | input | 1 | Event level; rising edges are counted |
| mode_i | input | 3 | Mode code |
| opt_i | input | 1 | Start option bit |
| cmp_i | input | CNT_W | Compare / reload value |
| count_o | output | CNT_W | Live counter value |
| capt_o | output | CNT_W | Captured count |
| irq_o | output | 1 | One-clock interrupt pulse |
| tout_o | output | 1 | Timer output, toggled on interrupts |

## Verification
The bench builds the channel with the default CNT_W of 16 and uses compare values of 0 to 10. With those values the reload boundary, the divide-by-one case (compare zero) and the one-shot stop are all reached within a few clocks. Interrupts and output toggles are counted over fixed windows for each mode and option. The retrigger, ignore and capture edges are placed at known counts, so that each option bit and each mode change shows up as a distinct count value at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] CODE_IVL  = 3'b000;
   localparam logic [MODE_W-1:0] CODE_CAP  = 3'b010;
   localparam logic [MODE_W-1:0] CODE_EVT  = 3'b011;
   localparam logic [MODE_W-1:0] CODE_ONE  = 3'b100;
   localparam logic [MODE_W-1:0] CODE_CAP1 = 3'b110;

   typedef enum logic [2:0] {
      K_IDLE,
      K_IVL,
      K_CAP,
      K_EVT,
      K_ONE,
      K_CAP1
   } kind_e;

endpackage

// File: rtl/tmr_sample.sv
// Keeps the value of each level input from one clock earlier, for edge finding.
module tmr_sample #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] prev_o
);

   if (N < 1) begin : g_bad_n
      $error("tmr_sample: N must be at least 1");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_o[b] <= 1'b0;
         else        prev_o[b] <= lvl_i[b];
      end
   end

endmodule

// File: rtl/tmr_mode_dec.sv
// Maps the raw mode code onto a function kind; prohibited codes map to idle.
module tmr_mode_dec
   import tmr_pkg::*;
(
   input  logic [MODE_W-1:0] mode_i,
   output kind_e             kind_o,
   output logic              valid_o
);

   always_comb begin
      unique case (mode_i)
         CODE_IVL:  kind_o = K_IVL;
         CODE_CAP:  kind_o = K_CAP;
         CODE_EVT:  kind_o = K_EVT;
         CODE_ONE:  kind_o = K_ONE;
         CODE_CAP1: kind_o = K_CAP1;
         default:   kind_o = K_IDLE;
      endcase
      valid_o = (kind_o != K_IDLE);
   end

endmodule

// File: rtl/tmr_core.sv
// Counter, capture register, interrupt and output state for one channel.
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  kind_e             kind_i,
   input  logic              valid_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              opt_i,
   input  logic              start_i,
   input  logic              trig_now_i,
   input  logic              trig_prev_i,
   input  logic              evt_now_i,
   input  logic              evt_prev_i,
   input  logic [CNT_W-1:0]  cmp_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  capt_o,
   output logic              irq_o,
   output logic              tout_o
);

   localparam logic [CNT_W-1:0] ZERO_V = '0;
   localparam logic [CNT_W-1:0] STEP_V = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0]  cnt_q, capt_q;
   logic              run_q, irq_q, tout_q;
   logic [MODE_W-1:0] mode_q;

   logic trig_rise, trig_fall, evt_rise;
   logic trigger;     // start request for the one-shot kinds
   logic down_tick;   // decrement strobe for the divider kinds
   logic start_flag;  // start raises irq and toggles output
   logic at_zero;

   always_comb begin
      trig_rise  = trig_now_i & ~trig_prev_i;
      trig_fall  = ~trig_now_i & trig_prev_i;
      evt_rise   = evt_now_i & ~evt_prev_i;
      trigger    = start_i | trig_rise;
      down_tick  = (kind_i == K_EVT) ? evt_rise : 1'b1;
      start_flag = opt_i & ((kind_i == K_IVL) | (kind_i == K_CAP));
      at_zero    = (cnt_q == ZERO_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= ZERO_V;
         capt_q <= ZERO_V;
         run_q  <= 1'b0;
         irq_q  <= 1'b0;
         tout_q <= 1'b0;
         mode_q <= CODE_IVL;
      end else begin
         irq_q <= 1'b0;
         if (!valid_i) begin
            cnt_q  <= ZERO_V;
            run_q  <= 1'b0;
            mode_q <= mode_i;
         end else if (mode_i != mode_q) begin
            mode_q <= mode_i;
            run_q  <= 1'b0;
         end else begin
            unique case (kind_i)
               K_IVL, K_EVT: begin
                  if (!run_q) begin
                     if (start_i) begin
                        cnt_q <= cmp_i;
                        run_q <= 1'b1;
                        if (start_flag) begin
                           irq_q  <= 1'b1;
                           tout_q <= ~tout_q;
                        end
                     end
                  end else if (down_tick) begin
                     if (at_zero) begin
                        cnt_q  <= cmp_i;
                        irq_q  <= 1'b1;
                        tout_q <= ~tout_q;
                     end else begin
                        cnt_q <= cnt_q - STEP_V;
                     end
                  end
               end
               K_CAP: begin
                  if (!run_q) begin
                     if (start_i) begin
                        cnt_q <= ZERO_V;
                        run_q <= 1'b1;
                        if (start_flag) begin
                           irq_q  <= 1'b1;
                           tout_q <= ~tout_q;
                        end
                     end
                  end else if (trig_rise) begin
                     capt_q <= cnt_q;
                     cnt_q  <= ZERO_V;
                     irq_q  <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + STEP_V;
                  end
               end
               K_ONE: begin
                  if (!run_q) begin
                     if (trigger) begin
                        cnt_q <= cmp_i;
                        run_q <= 1'b1;
                     end
                  end else if (trigger && opt_i) begin
                     cnt_q <= cmp_i;
                  end else if (at_zero) begin
                     irq_q  <= 1'b1;
                     tout_q <= ~tout_q;
                     run_q  <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q - STEP_V;
                  end
               end
               K_CAP1: begin
                  if (!run_q) begin
                     if (trigger) begin
                        cnt_q <= ZERO_V;
                        run_q <= 1'b1;
                     end
                  end else if (trig_fall) begin
                     capt_q <= cnt_q;
                     irq_q  <= 1'b1;
                     run_q  <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q + STEP_V;
                  end
               end
               default: begin
                  run_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign count_o = cnt_q;
   assign capt_o  = capt_q;
   assign irq_o   = irq_q;
   assign tout_o  = tout_q;

endmodule

// File: rtl/timer_channel.sv
module timer_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              trig_i,
   input  logic              evt_i,
   input  logic [2:0]        mode_i,
   input  logic              opt_i,
   input  logic [CNT_W-1:0]  cmp_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  capt_o,
   output logic              irq_o,
   output logic              tout_o
);

   localparam int LVL_N = 2;   // bit 0 trigger, bit 1 event

   if (CNT_W < 2) begin : g_bad_width
      $error("timer_channel: CNT_W must be at least 2");
   end

   logic [LVL_N-1:0] lvl_now, lvl_prev;
   kind_e            kind;
   logic             mode_ok;

   assign lvl_now = {evt_i, trig_i};

   tmr_sample #(.N(LVL_N)) u_sample (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl_now),
      .prev_o (lvl_prev)
   );

   tmr_mode_dec u_dec (
      .mode_i  (mode_i),
      .kind_o  (kind),
      .valid_o (mode_ok)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind_i      (kind),
      .valid_i     (mode_ok),
      .mode_i      (mode_i),
      .opt_i       (opt_i),
      .start_i     (start_i),
      .trig_now_i  (lvl_now[0]),
      .trig_prev_i (lvl_prev[0]),
      .evt_now_i   (lvl_now[1]),
      .evt_prev_i  (lvl_prev[1]),
      .cmp_i       (cmp_i),
      .count_o     (count_o),
      .capt_o      (capt_o),
      .irq_o       (irq_o),
      .tout_o      (tout_o)
   );

endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             evt_i,
   input logic [2:0]       mode_i,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] capt_o,
   input logic             irq_o,
   input logic             tout_o
);

   // R2
   prohib_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'b001 || mode_i == 3'b101 || mode_i == 3'b111)
      |=> (count_o == '0 && !irq_o));

   // R12
   tout_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tout_o) |-> irq_o);

   // R12
   capt_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capt_o) |-> irq_o);

   // R7
   evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'b011 && !start_i && !(evt_i && !$past(evt_i)))
      |=> $stable(count_o));

endmodule

bind timer_channel timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .evt_i   (evt_i),
   .mode_i  (mode_i),
   .count_o (count_o),
   .capt_o  (capt_o),
   .irq_o   (irq_o),
   .tout_o  (tout_o)
);

// File: tb/tb_timer_channel.sv
`timescale 1ns/1ps
module tb_timer_channel;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         trig_i = 1'b0;
   logic         evt_i = 1'b0;
   logic [2:0]   mode_i = 3'b111;
   logic         opt_i = 1'b0;
   logic [W-1:0] cmp_i = '0;
   logic [W-1:0] count_o, capt_o;
   logic         irq_o, tout_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   timer_channel #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
      .evt_i(evt_i), .mode_i(mode_i), .opt_i(opt_i), .cmp_i(cmp_i),
      .count_o(count_o), .capt_o(capt_o), .irq_o(irq_o), .tout_o(tout_o)
   );

   typedef struct packed {
      logic [2:0]  mode;
      logic        opt;
      logic [15:0] cmp;
      logic [7:0]  win;
      logic [15:0] e_cnt;
      logic [7:0]  e_irq;
      logic [7:0]  e_tog;
   } vec_t;

   // window of samples after a start_i pulse; expected final count, irq pulses, toggles
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{3'b000, 1'b0, 16'd3, 8'd10, 16'd2, 8'd2, 8'd2},  // R4
      '{3'b000, 1'b1, 16'd3, 8'd10, 16'd2, 8'd3, 8'd3},  // R5
      '{3'b000, 1'b0, 16'd0, 8'd5,  16'd0, 8'd4, 8'd4},  // R4 cmp zero
      '{3'b010, 1'b0, 16'd9, 8'd6,  16'd5, 8'd0, 8'd0},  // R6
      '{3'b010, 1'b1, 16'd9, 8'd6,  16'd5, 8'd1, 8'd1},  // R5
      '{3'b011, 1'b1, 16'd7, 8'd5,  16'd7, 8'd0, 8'd0},  // R7
      '{3'b100, 1'b0, 16'd2, 8'd8,  16'd0, 8'd1, 8'd1},  // R8
      '{3'b100, 1'b1, 16'd2, 8'd8,  16'd0, 8'd1, 8'd1},  // R8
      '{3'b110, 1'b1, 16'd9, 8'd4,  16'd3, 8'd0, 8'd0},  // R11
      '{3'b001, 1'b1, 16'd5, 8'd4,  16'd0, 8'd0, 8'd0}   // R2
   };

   task automatic chk(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // pass through a prohibited code so the channel is stopped, then select a mode
   task automatic set_mode(input logic [2:0] m, input logic o, input logic [W-1:0] c);
      mode_i = 3'b111;
      step();
      step();
      mode_i = m;
      opt_i  = o;
      cmp_i  = c;
      step();
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      step();
      start_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 count", int'(count_o), 0);
      chk("R1 capt", int'(capt_o), 0);
      chk("R1 irq", int'(irq_o), 0);
      chk("R1 tout", int'(tout_o), 0);
      rst_n = 1'b1;
      step();

      for (int v = 0; v < NV; v++) begin
         int  n_irq;
         int  n_tog;
         logic prev_t;
         string tag;
         tag = $sformatf("vec%0d", v);
         set_mode(VECS[v].mode, VECS[v].opt, VECS[v].cmp);
         prev_t = tout_o;
         n_irq = 0;
         n_tog = 0;
         pulse_start();
         for (int j = 0; j < int'(VECS[v].win); j++) begin
            if (irq_o) n_irq++;
            if (tout_o != prev_t) n_tog++;
            prev_t = tout_o;
            if (j != int'(VECS[v].win) - 1) step();
         end
         chk({tag, " R4-R11 mode count"}, int'(count_o), int'(VECS[v].e_cnt));
         chk({tag, " R5 irq pulses"}, n_irq, int'(VECS[v].e_irq));
         chk({tag, " R12 toggles"}, n_tog, int'(VECS[v].e_tog));
      end

      // R6 capture on rising trigger edge
      set_mode(3'b010, 1'b0, 16'd0);
      pulse_start();
      step(); step(); step();
      trig_i = 1'b1;
      step();
      chk("R6 capt", int'(capt_o), 3);
      chk("R6 irq", int'(irq_o), 1);
      chk("R6 count cleared", int'(count_o), 0);
      trig_i = 1'b0;
      step();
      chk("R6 irq single", int'(irq_o), 0);

      // R7 event counting
      set_mode(3'b011, 1'b0, 16'd2);
      pulse_start();
      begin
         logic t0;
         t0 = tout_o;
         for (int e = 0; e < 3; e++) begin
            evt_i = 1'b1;
            step();
            if (e == 2) begin
               chk("R7 reload irq", int'(irq_o), 1);
               chk("R7 reload count", int'(count_o), 2);
               chk("R7 toggle", int'(tout_o != t0), 1);
            end
            evt_i = 1'b0;
            step();
         end
      end

      // R9 one-count retrigger ignored
      set_mode(3'b100, 1'b0, 16'd5);
      pulse_start();
      step(); step();
      trig_i = 1'b1;
      step();
      chk("R9 retrigger ignored", int'(count_o), 2);
      trig_i = 1'b0;
      step();

      // R10 one-count retrigger reloads
      set_mode(3'b100, 1'b1, 16'd5);
      pulse_start();
      step(); step();
      trig_i = 1'b1;
      step();
      chk("R10 reload count", int'(count_o), 5);
      chk("R10 no irq", int'(irq_o), 0);
      trig_i = 1'b0;
      step();

      // R11 capture-and-one-count driven by the trigger level
      set_mode(3'b110, 1'b0, 16'd0);
      trig_i = 1'b1;
      step();
      chk("R11 start no irq", int'(irq_o), 0);
      step();
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk("R11 start ignored", int'(count_o), 2);
      trig_i = 1'b0;
      step();
      chk("R11 capt", int'(capt_o), 2);
      chk("R11 irq", int'(irq_o), 1);
      step();
      chk("R11 stopped", int'(count_o), 2);

      // R3 mode change stops the channel
      set_mode(3'b000, 1'b0, 16'd10);
      pulse_start();
      step(); step(); step();
      mode_i = 3'b010;
      step();
      step(); step();
      chk("R3 held count", int'(count_o), 7);
      chk("R3 no irq", int'(irq_o), 0);

      done = 1'b1;
      finish_run();
   end

endmodule